// File: doc/BRIEF.md
# Branch Target Address Calculator

This block forms the next program counter for the jump and branch forms of an 8-bit accumulator-style microcontroller core. Every cycle it takes the address of the first byte of the instruction that follows the branch, a two-bit form select, the operand fields of the three branch forms, and a flag that says whether the branch is taken. From these it builds the 16-bit target address and chooses the next program counter. Both results are registered and appear one clock after the inputs are sampled.

Three target forms are supported. The page form replaces the low 11 bits of the following-instruction address with an 11-bit operand, so the target never leaves the 2 KB page of that address. The relative form adds a signed 8-bit offset (reach of -128 to +127 bytes) to the following-instruction address, wrapping modulo 2^16. The long form takes a 16-bit operand as the target, reaching any code location. Deciding whether a condition holds, saving return addresses and fetching instructions are left to neighbouring logic.

The block has no control state machine: its only states are the reset state and the running state. Under reset both outputs are held at zero; after reset the output registers load on each rising clock edge.

Top module: `bta_calc`

## Requirements
- R1: While `rst_n` is low, `target_pc` and `next_pc` are both 0x0000.
- R2: With `form` = 2'b00 (page form), `target_pc` = {`follow_pc[15:11]`, `page_ofs[10:0]`}; the upper five bits never differ from those of `follow_pc`, even when `page_ofs` is 0x000 or 0x7FF.
- R3: With `form` = 2'b01 (relative form), `target_pc` = (`follow_pc` + sign-extended `rel_ofs`) mod 2^16, where `rel_ofs` is two's complement covering -128 to +127.
- R4: With `form` = 2'b10 (long form), `target_pc` = `long_addr`.
- R5: With `form` = 2'b11 (no branch form), `target_pc` = `follow_pc` and `next_pc` = `follow_pc` whatever `taken` is.
- R6: When `taken` is low, `next_pc` = `follow_pc` for every form.
- R7: When `taken` is high and `form` is not 2'b11, `next_pc` = `target_pc`.
- R8: Outputs reflect the inputs sampled at the previous rising edge of `clk` (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| follow_pc | input | 16 | Address of the first byte of the following instruction |
| form | input | 2 | Target form: 00 page, 01 relative, 10 long, 11 none |
| page_ofs | input | 11 | In-page target bits for the page form |
| rel_ofs | input | 8 | Signed offset for the relative form |
| long_addr | input | 16 | Full target for the long form |
| taken | input | 1 | Branch taken flag |
| target_pc | output | 16 | Registered target address |
| next_pc | output | 16 | Registered next program counter |

## Verification
Assertions check on every cycle that the page form keeps the upper five bits of the previous cycle's following address and copies the in-page bits, that a relative target lies within the signed 8-bit reach of that address, that a long target equals the operand, and that the taken flag alone steers the next program counter between the following address and the target. Exact wrap results, such as a +127 offset from 0xFFF0 landing at 0x006F or a -128 offset from 0x0010 landing at 0xFF90, and the reset values, are shown only by the bench's directed scenarios and its seeded random mix compared against its own model.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        FORM_PAGE = 2'b00,
        FORM_REL  = 2'b01,
        FORM_LONG = 2'b10,
        FORM_NONE = 2'b11
    } br_form_t;
endpackage

// File: rtl/bta_rel_adder.sv
module bta_rel_adder #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 8
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  sum_pc
);
    localparam int EXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        sum_pc  = base_pc + ofs_ext;
    end
endmodule

// File: rtl/bta_form_mux.sv
module bta_form_mux
    import bta_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 11
) (
    input  br_form_t          form,
    input  logic [PC_W-1:0]   follow_pc,
    input  logic [PAGE_W-1:0] page_ofs,
    input  logic [PC_W-1:0]   rel_sum,
    input  logic [PC_W-1:0]   long_addr,
    input  logic              taken,
    output logic [PC_W-1:0]   target,
    output logic [PC_W-1:0]   next
);
    localparam int HI_W = PC_W - PAGE_W;

    always_comb begin
        unique case (form)
            FORM_PAGE: target = {follow_pc[PC_W-1 -: HI_W], page_ofs};
            FORM_REL:  target = rel_sum;
            FORM_LONG: target = long_addr;
            FORM_NONE: target = follow_pc;
            default:   target = follow_pc;
        endcase
        next = (taken && form != FORM_NONE) ? target : follow_pc;
    end
endmodule

// File: rtl/bta_calc.sv
module bta_calc
    import bta_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   follow_pc,
    input  logic [1:0]        form,
    input  logic [PAGE_W-1:0] page_ofs,
    input  logic [OFS_W-1:0]  rel_ofs,
    input  logic [PC_W-1:0]   long_addr,
    input  logic              taken,
    output logic [PC_W-1:0]   target_pc,
    output logic [PC_W-1:0]   next_pc
);
    localparam int HI_W = PC_W - PAGE_W;
    localparam logic [PC_W-1:0] HALF_REACH = PC_W'(1) << (OFS_W - 1);
    localparam logic [PC_W-1:0] FULL_REACH = PC_W'(1) << OFS_W;

    br_form_t        form_e;
    logic [PC_W-1:0] rel_sum;
    logic [PC_W-1:0] target_d;
    logic [PC_W-1:0] next_d;
    logic            primed;

    assign form_e = br_form_t'(form);

    bta_rel_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
        .base_pc (follow_pc),
        .ofs     (rel_ofs),
        .sum_pc  (rel_sum)
    );

    bta_form_mux #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_mux (
        .form      (form_e),
        .follow_pc (follow_pc),
        .page_ofs  (page_ofs),
        .rel_sum   (rel_sum),
        .long_addr (long_addr),
        .taken     (taken),
        .target    (target_d),
        .next      (next_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_pc <= '0;
            next_pc   <= '0;
            primed    <= 1'b0;
        end else begin
            target_pc <= target_d;
            next_pc   <= next_d;
            primed    <= 1'b1;
        end
    end

    AST_PAGE_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(form) == FORM_PAGE) |->
        target_pc[PC_W-1 -: HI_W] == $past(follow_pc[PC_W-1 -: HI_W])); // R2
    AST_PAGE_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(form) == FORM_PAGE) |->
        target_pc[PAGE_W-1:0] == $past(page_ofs)); // R2
    AST_REL_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(form) == FORM_REL) |->
        PC_W'(target_pc - $past(follow_pc) + HALF_REACH) < FULL_REACH); // R3
    AST_LONG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(form) == FORM_LONG) |-> target_pc == $past(long_addr)); // R4
    AST_NONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(form) == FORM_NONE) |-> next_pc == $past(follow_pc)); // R5
    AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(taken)) |-> next_pc == $past(follow_pc)); // R6
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(taken) && $past(form) != FORM_NONE) |-> next_pc == target_pc); // R7
    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(!rst_n) |-> (target_pc == '0 && next_pc == '0)); // R1
endmodule

// File: tb/sim_bta_calc.sv
`timescale 1ns/1ps
module sim_bta_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] follow_pc = '0;
    logic [1:0]  form = '0;
    logic [10:0] page_ofs = '0;
    logic [7:0]  rel_ofs = '0;
    logic [15:0] long_addr = '0;
    logic        taken = 1'b0;
    logic [15:0] target_pc;
    logic [15:0] next_pc;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bta_calc u0 (
        .clk(clk), .rst_n(rst_n), .follow_pc(follow_pc), .form(form),
        .page_ofs(page_ofs), .rel_ofs(rel_ofs), .long_addr(long_addr),
        .taken(taken), .target_pc(target_pc), .next_pc(next_pc)
    );

    function automatic logic [15:0] exp_target(input logic [1:0] f, input logic [15:0] fp,
                                               input logic [10:0] po, input logic [7:0] ro,
                                               input logic [15:0] la);
        case (f)
            2'b00:   return {fp[15:11], po};
            2'b01:   return fp + {{8{ro[7]}}, ro};
            2'b10:   return la;
            default: return fp;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [1:0] f, input logic tk,
                                             input logic [15:0] fp, input logic [15:0] tg);
        return (tk && f != 2'b11) ? tg : fp;
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge load the registers (R8), sample at the next falling edge.
    task automatic apply(input logic [1:0] f, input logic [15:0] fp, input logic [10:0] po,
                         input logic [7:0] ro, input logic [15:0] la, input logic tk);
        logic [15:0] et;
        logic [15:0] en;
        string tr;
        string nr;
        @(negedge clk);
        form = f; follow_pc = fp; page_ofs = po; rel_ofs = ro; long_addr = la; taken = tk;
        et = exp_target(f, fp, po, ro, la);
        en = exp_next(f, tk, fp, et);
        @(negedge clk);
        case (f)
            2'b00:   tr = "R2 page target (R8)";
            2'b01:   tr = "R3 relative target (R8)";
            2'b10:   tr = "R4 long target (R8)";
            default: tr = "R5 no-branch target (R8)";
        endcase
        if (f == 2'b11)  nr = "R5 no-branch next";
        else if (!tk)    nr = "R6 not-taken next";
        else             nr = "R7 taken next";
        check16(tr, target_pc, et);
        check16(nr, next_pc, en);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: hold reset with non-zero inputs
        follow_pc = 16'hABCD; form = 2'b10; long_addr = 16'h1234; taken = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check16("R1 reset target", target_pc, 16'h0000);
        check16("R1 reset next", next_pc, 16'h0000);
        rst_n = 1'b1;

        // R3 offsets at the edges of the reach, with wrap at both ends
        apply(2'b01, 16'h1000, '0, 8'h80, '0, 1'b1);   // -128
        apply(2'b01, 16'h1000, '0, 8'hFF, '0, 1'b1);   // -1
        apply(2'b01, 16'h1000, '0, 8'h00, '0, 1'b1);   // 0
        apply(2'b01, 16'h1000, '0, 8'h7F, '0, 1'b1);   // +127
        apply(2'b01, 16'hFFF0, '0, 8'h7F, '0, 1'b1);   // wrap up to 0x006F
        apply(2'b01, 16'h0010, '0, 8'h80, '0, 1'b1);   // wrap down to 0xFF90
        apply(2'b01, 16'hFFFF, '0, 8'h01, '0, 1'b1);   // 0xFFFF -> 0x0000
        apply(2'b01, 16'h0000, '0, 8'hFF, '0, 1'b1);   // 0x0000 -> 0xFFFF
        // R2 page edges: never crosses into the neighbouring page
        apply(2'b00, 16'h0800, 11'h7FF, '0, '0, 1'b1);
        apply(2'b00, 16'h07FF, 11'h000, '0, '0, 1'b1);
        apply(2'b00, 16'hFFFF, 11'h000, '0, '0, 1'b1);
        apply(2'b00, 16'hF800, 11'h7FF, '0, '0, 1'b1);
        // R4 long form anywhere
        apply(2'b10, 16'h0002, '0, '0, 16'hFFFF, 1'b1);
        apply(2'b10, 16'hFFFE, '0, '0, 16'h0000, 1'b1);
        // R6 not taken, R5 no-branch form even when taken
        apply(2'b10, 16'h4321, '0, '0, 16'h9999, 1'b0);
        apply(2'b01, 16'h4321, '0, 8'h80, '0, 1'b0);
        apply(2'b11, 16'h5555, 11'h123, 8'h44, 16'h7777, 1'b1);
        apply(2'b11, 16'h5555, 11'h123, 8'h44, 16'h7777, 1'b0);

        // Seeded random mix over all forms (R2..R8)
        for (int i = 0; i < 400; i++) begin
            apply(2'($urandom), 16'($urandom), 11'($urandom), 8'($urandom),
                  16'($urandom), 1'($urandom));
        end

        // R1 again: reset in the middle clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check16("R1 mid-run reset target", target_pc, 16'h0000);
        check16("R1 mid-run reset next", next_pc, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule